// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Packed-BCD Arithmetic

This block is the arithmetic and logic stage of an 8-bit accumulator processor. Each enabled cycle it takes an operation code, the accumulator operand A, a memory operand M, the incoming carry and the decimal-mode status bit. On the next clock edge it presents the 8-bit result, the new negative, overflow, zero and carry flags, and a mask that tells the surrounding core which of those flags the operation writes. Register files, memory access and instruction decode live outside the block.

Addition and subtraction run in plain binary or, when the decimal-mode bit is set, on packed BCD operands (two decimal digits per byte). Subtraction uses the carry as an inverted borrow, so a carry of 1 means "nothing borrowed". Besides the arithmetic the block covers the three bitwise operations, single-bit shifts, rotates through carry, compare, bit test, increment and decrement. Flags and mask are presented in the status-byte layout the rest of the core uses, so they can be merged into the status register with a single masked write.

The reset input is asynchronous and active low; its release is synchronised inside the block, so outputs keep their reset value for two clock edges after the input goes high. While the enable is low the outputs hold.

Top module: `ucalc_core`

## Requirements
- R1: While reset is applied, and for two rising edges after its release, `res_o`, `flg_o` and `wmask_o` are all zero; asserting reset clears them without waiting for a clock edge.
- R2: Opcode 0 with `dec_i`=0 gives A+M+`cin_i` modulo 256. C is the carry out of bit 7. V is set when A and M have the same sign and the result's sign differs from it. The mask covers N, V, Z and C.
- R3: Opcode 1 with `dec_i`=0 gives A-M-(1-`cin_i`) modulo 256. C is 1 when no borrow occurs, which includes a zero difference. V is set when A and the inverted M have the same sign and the result's sign differs from it. The mask covers N, V, Z and C.
- R4: Opcode 0 with `dec_i`=1 adds the decimal values of the packed-BCD operands and the carry. Above 99 it subtracts 100 and sets both C and V; otherwise C and V are 0. The result is re-encoded as packed BCD.
- R5: Opcode 1 with `dec_i`=1 subtracts the decimal value of M and the inverted carry from that of A. A negative difference gets 100 added and C cleared; otherwise C is set. V is 0 and the result is packed BCD.
- R6: Opcodes 2, 3 and 4 give A OR M, A AND M and A XOR M, and write only N and Z.
- R7: Opcode 5 shifts A left with a 0 fill and puts A bit 7 in C. Opcode 6 shifts A right with a 0 fill, puts A bit 0 in C and therefore leaves N at 0. Both write N, Z and C.
- R8: Opcode 7 rotates A left with the old carry entering bit 0. Opcode 8 rotates A right with the old carry entering bit 7. The bit pushed out lands in C, and both write N, Z and C.
- R9: Opcode 9 (compare) returns A unchanged as the result and writes N, Z and C. It sets Z and C when A equals M, only C when A is greater (unsigned), and only N when A is smaller.
- R10: Opcode 10 (bit test) returns A unchanged. It sets Z when A AND M is zero, copies M bit 7 into N and M bit 6 into V, and writes N, V and Z.
- R11: Opcode 11 gives A+1 and opcode 12 gives A-1, both wrapping modulo 256 and writing only N and Z.
- R12: `flg_o` and `wmask_o` use status-byte positions N=bit 7, V=bit 6, Z=bit 1 and C=bit 0; all other bits are 0, and a flag outside the mask reads 0. Except for compare and bit test, N is result bit 7 and Z is set when the 8-bit result is zero.
- R13: With `en` low all outputs hold their values. Opcodes 13 to 15 return A with flags and mask of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable; the operation is captured when high |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand A |
| m_i | input | 8 | Memory operand M |
| cin_i | input | 1 | Incoming carry flag |
| dec_i | input | 1 | Decimal-mode status bit |
| res_o | output | 8 | Registered result |
| flg_o | output | 8 | Updated flags in status-byte layout |
| wmask_o | output | 8 | Flags written by the operation, same layout |

## Verification
The bench aims at the edges of the arithmetic. It runs a decimal sum of exactly 100, where a design that fails to wrap returns a non-BCD byte and leaves Z clear. It runs a decimal difference of exactly zero with a pending borrow, where a design with the borrow sense inverted clears C. Binary subtraction is run with carry in both states and across the signed limit (0x80-1), so a design that applies the borrow the wrong way, or computes V from the uninverted M, gives a result off by one or a wrong V. The compare case 0x01 versus 0xFF would expose an N taken from the difference's bit 7 rather than the ordering. Increment from 0xFF, decrement from 0x00, a right shift into zero and an unused opcode check wrapping, the cleared N and the empty mask.

// File: rtl/ucalc_pkg.sv
package ucalc_pkg;
  localparam int DW  = 8;
  localparam int OPW = 4;
  localparam int FW  = 8;

  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_V = 6;
  localparam int FB_N = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_OR  = 4'd2,
    OP_AND = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_CMP = 4'd9,
    OP_BIT = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } op_e;
endpackage

// File: rtl/ucalc_bin_arith.sv
module ucalc_bin_arith #(
  parameter int W = ucalc_pkg::DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] m_eff;
  logic [W:0]   wide;

  always_comb begin
    m_eff = sub ? ~m : m;
    wide  = {1'b0, a} + {1'b0, m_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (a[W-1] == m_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/ucalc_dec_arith.sv
module ucalc_dec_arith (
  input  logic [7:0] a,
  input  logic [7:0] m,
  input  logic       cin,
  input  logic       sub,
  output logic [7:0] sum,
  output logic       cout
);
  localparam int VW = 11;

  logic signed [VW-1:0] av, mv, raw, fix;
  logic [7:0]           t8;

  always_comb begin
    av = VW'(a[7:4]) * 11'sd10 + VW'(a[3:0]);
    mv = VW'(m[7:4]) * 11'sd10 + VW'(m[3:0]);
    if (sub) begin
      raw  = av - mv - VW'(!cin);
      cout = (raw >= 0);
      fix  = cout ? raw : raw + 11'sd100;
    end else begin
      raw  = av + mv + VW'(cin);
      cout = (raw > 11'sd99);
      fix  = cout ? raw - 11'sd100 : raw;
    end
    t8  = fix[7:0];
    sum = {4'((t8 / 8'd10) % 8'd10), 4'(t8 % 8'd10)};
  end
endmodule

// File: rtl/ucalc_logic.sv
module ucalc_logic #(
  parameter int W = ucalc_pkg::DW
) (
  input  ucalc_pkg::op_e op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cout
);
  import ucalc_pkg::*;

  always_comb begin
    res  = a;
    cout = 1'b0;
    case (op)
      OP_OR:  res = a | m;
      OP_AND: res = a & m;
      OP_XOR: res = a ^ m;
      OP_SHL: begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
      OP_SHR: begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
      OP_ROL: begin res = {a[W-2:0], cin};  cout = a[W-1]; end
      OP_ROR: begin res = {cin, a[W-1:1]};  cout = a[0];   end
      OP_INC: res = a + W'(1);
      OP_DEC: res = a - W'(1);
      default: res = a;
    endcase
  end
endmodule

// File: rtl/ucalc_core.sv
module ucalc_core #(
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] op_i,
  input  logic [7:0] a_i,
  input  logic [7:0] m_i,
  input  logic       cin_i,
  input  logic       dec_i,
  output logic [7:0] res_o,
  output logic [7:0] flg_o,
  output logic [7:0] wmask_o
);
  import ucalc_pkg::*;

  localparam int W = DW;

  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  op_e          op;
  logic [W-1:0] bin_sum, dec_sum, lg_res;
  logic         bin_c, bin_v, dec_c, lg_c;
  logic         is_sub;

  assign op     = op_e'(op_i);
  assign is_sub = (op_i == OP_SUB);

  ucalc_bin_arith #(.W(W)) u_bin (
    .a(a_i), .m(m_i), .cin(cin_i), .sub(is_sub),
    .sum(bin_sum), .cout(bin_c), .ovf(bin_v)
  );

  generate
    if (DECIMAL_EN) begin : g_dec
      ucalc_dec_arith u_dec (
        .a(a_i), .m(m_i), .cin(cin_i), .sub(is_sub),
        .sum(dec_sum), .cout(dec_c)
      );
    end else begin : g_nodec
      assign dec_sum = bin_sum;
      assign dec_c   = bin_c;
    end
  endgenerate

  ucalc_logic #(.W(W)) u_lg (
    .op(op), .a(a_i), .m(m_i), .cin(cin_i),
    .res(lg_res), .cout(lg_c)
  );

  // next-state: flags kept as {N,V,Z,C}
  logic [W-1:0] res_d;
  logic [3:0]   f_d, mk_d, f_q, mk_q;
  logic [W-1:0] res_q;
  logic         use_dec;

  assign use_dec = DECIMAL_EN && dec_i;

  always_comb begin
    res_d = a_i;
    f_d   = 4'b0000;
    mk_d  = 4'b0000;
    case (op)
      OP_ADD, OP_SUB: begin
        mk_d = 4'b1111;
        if (use_dec) begin
          res_d = dec_sum;
          f_d   = {dec_sum[W-1], dec_c && !is_sub, dec_sum == '0, dec_c};
        end else begin
          res_d = bin_sum;
          f_d   = {bin_sum[W-1], bin_v, bin_sum == '0, bin_c};
        end
      end
      OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC: begin
        res_d = lg_res;
        mk_d  = 4'b1010;
        f_d   = {lg_res[W-1], 1'b0, lg_res == '0, 1'b0};
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_d = lg_res;
        mk_d  = 4'b1011;
        f_d   = {lg_res[W-1], 1'b0, lg_res == '0, lg_c};
      end
      OP_CMP: begin
        mk_d = 4'b1011;
        f_d  = {a_i < m_i, 1'b0, a_i == m_i, a_i >= m_i};
      end
      OP_BIT: begin
        mk_d = 4'b1110;
        f_d  = {m_i[W-1], m_i[W-2], (a_i & m_i) == '0, 1'b0};
      end
      default: begin
        res_d = a_i;
        mk_d  = 4'b0000;
      end
    endcase
    f_d = f_d & mk_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_q <= '0;
      f_q   <= '0;
      mk_q  <= '0;
    end else if (en) begin
      res_q <= res_d;
      f_q   <= f_d;
      mk_q  <= mk_d;
    end
  end

  assign res_o   = res_q;
  assign flg_o   = {f_q[3], f_q[2], 4'b0000, f_q[1], f_q[0]};
  assign wmask_o = {mk_q[3], mk_q[2], 4'b0000, mk_q[1], mk_q[0]};
endmodule

// File: rtl/ucalc_core_chk.sv
module ucalc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] op_i,
  input logic [7:0] a_i,
  input logic [7:0] m_i,
  input logic [7:0] res_o,
  input logic [7:0] flg_o,
  input logic [7:0] wmask_o
);
  import ucalc_pkg::*;

  AST_FLAGS_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_o & ~wmask_o) == 8'h00); // R12

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> ($stable(res_o) && $stable(flg_o) && $stable(wmask_o))); // R13

  AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && $past(op_i) == OP_CMP) |-> (res_o == $past(a_i))); // R9

  AST_SHR_N_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && $past(op_i) == OP_SHR) |-> (!flg_o[FB_N] && flg_o[FB_C] == $past(a_i[0]))); // R7

  AST_BIT_COPIES_M: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && $past(op_i) == OP_BIT) |-> ({flg_o[FB_N], flg_o[FB_V]} == $past(m_i[7:6]))); // R10

  AST_INCDEC_NZ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
      |-> (wmask_o == 8'h82)); // R11

  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en) && $past(op_i) <= OP_ROR) |-> (flg_o[FB_Z] == (res_o == 8'h00))); // R12
endmodule

bind ucalc_core ucalc_core_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .en(en), .op_i(op_i), .a_i(a_i), .m_i(m_i),
  .res_o(res_o), .flg_o(flg_o), .wmask_o(wmask_o)
);

// File: tb/tb_ucalc_core.sv
module tb_ucalc_core;
  logic       clk = 1'b0;
  logic       rst_n, en, cin_i, dec_i;
  logic [3:0] op_i;
  logic [7:0] a_i, m_i, res_o, flg_o, wmask_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ucalc_core dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op_i(op_i), .a_i(a_i), .m_i(m_i),
    .cin_i(cin_i), .dec_i(dec_i), .res_o(res_o), .flg_o(flg_o), .wmask_o(wmask_o)
  );

  // fields: req | op | A | M | status nibble (8=D,1=C) | result | NVZC | mask NVZC
  localparam int NV = 30;
  localparam logic [43:0] VEC [NV] = '{
    44'h2_0_50_50_0_A0_C_F, // R2 signed overflow
    44'h2_0_FF_01_0_00_3_F, // R2 carry out, zero
    44'h2_0_10_20_1_31_0_F, // R2 carry in
    44'h3_1_50_10_1_40_1_F, // R3 no borrow
    44'h3_1_50_10_0_3F_1_F, // R3 borrow in
    44'h3_1_10_20_1_F0_8_F, // R3 borrow out
    44'h3_1_80_01_1_7F_5_F, // R3 signed overflow
    44'h4_0_45_38_8_83_8_F, // R4 BCD no carry
    44'h4_0_58_46_9_05_5_F, // R4 BCD carry in and out
    44'h4_0_50_50_8_00_7_F, // R4 BCD exactly 100
    44'h5_1_42_15_9_27_1_F, // R5 BCD positive
    44'h5_1_15_42_9_73_0_F, // R5 BCD negative wraps
    44'h5_1_30_29_8_00_3_F, // R5 BCD zero with borrow
    44'h6_2_0F_F0_0_FF_8_A, // R6 OR
    44'h6_3_0F_F0_0_00_2_A, // R6 AND
    44'h6_4_AA_2A_0_80_8_A, // R6 XOR
    44'h7_5_81_00_0_02_1_B, // R7 shift left
    44'h7_6_81_00_0_40_1_B, // R7 shift right
    44'h7_6_01_00_0_00_3_B, // R7 shift right to zero
    44'h8_7_80_00_1_01_1_B, // R8 rotate left
    44'h8_8_01_00_1_80_9_B, // R8 rotate right carry in
    44'h8_8_02_00_0_01_0_B, // R8 rotate right carry clear
    44'h9_9_40_40_0_40_3_B, // R9 equal
    44'h9_9_41_40_0_41_1_B, // R9 greater
    44'h9_9_01_FF_0_01_8_B, // R9 less
    44'hA_A_0F_C0_0_0F_E_E, // R10 zero, N and V copied
    44'hA_A_01_41_0_01_4_E, // R10 nonzero
    44'hB_B_FF_00_1_00_2_A, // R11 increment wraps
    44'hB_C_00_00_0_FF_8_A, // R11 decrement wraps
    44'hD_E_5A_33_1_5A_0_0  // R13 unused opcode
  };

  function automatic logic [7:0] place(input logic [3:0] nvzc);
    return {nvzc[3], nvzc[2], 4'b0000, nvzc[1], nvzc[0]};
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got res/flg/mask=%h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op_i = '0; a_i = '0; m_i = '0; cin_i = 1'b0; dec_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {res_o, flg_o, wmask_o}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1; op_i = 4'd4; a_i = 8'hFF; m_i = 8'h00;
    @(negedge clk);
    // second edge after release still in reset
    check("R1 release delay", {res_o, flg_o, wmask_o}, 24'h0);
    en = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      en = 1'b1; op_i = v[39:36]; a_i = v[35:28]; m_i = v[27:20];
      dec_i = v[19]; cin_i = v[16];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", v[43:40], i), {res_o, flg_o, wmask_o},
            {v[15:8], place(v[7:4]), place(v[3:0])});
    end

    // R13: enable low holds the previous result
    en = 1'b0; op_i = 4'd0; a_i = 8'h01; m_i = 8'h01; cin_i = 1'b0; dec_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 hold", {res_o, flg_o, wmask_o}, {8'h5A, 8'h00, 8'h00});

    // R4 versus R2: same operands, decimal bit decides
    en = 1'b1; op_i = 4'd0; a_i = 8'h09; m_i = 8'h01; cin_i = 1'b0; dec_i = 1'b1;
    @(negedge clk);
    check("R4 decimal 09+01", {res_o, flg_o, wmask_o}, {8'h10, 8'h00, 8'hC3});
    dec_i = 1'b0;
    @(negedge clk);
    check("R2 binary 09+01", {res_o, flg_o, wmask_o}, {8'h0A, 8'h00, 8'hC3});

    // R1: asynchronous clear mid-run
    en = 1'b0;
    #3 rst_n = 1'b0;
    #2 check("R1 async clear", {res_o, flg_o, wmask_o}, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", {res_o, flg_o, wmask_o}, 24'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule